// File: doc/BRIEF.md
# Segment-Interleaved Vector Load Sequencer with Zero Termination

This block drives one vector load in which each element consists of several consecutive fields in memory. For every active element index it reads the fields one at a time over a valid/ready request channel and waits for each response. It then writes the value into the destination vector register that belongs to that field, at the element's position in the register group. Inactive elements, as given by a mask bit, cost one cycle and cause no memory or register traffic.

The operation ends as soon as any loaded field is zero once reduced to the element width. The zero field is still written. The reported length then becomes that element's index, and a truncation flag is raised. Otherwise the load ends once the element index reaches the smaller of the requested length, the maximum length and the mask capacity. The reported length is then the requested one.

A configuration with an unsupported element width, or with a field count times group multiplier above a quarter of the register count, is refused at once: the block returns a done pulse with an illegal flag and makes no access. All configuration is captured on the start cycle.

Top module: `seg_vload_seq`

## Requirements
- R1: Element width codes are 0=8, 1=16, 2=32 and 3=64 bits. Codes 4 to 7 end the operation with a done pulse and illegal=1, with no read and no register write.
- R2: The field count is nf_sel+1. If field count × group_mul exceeds NUM_VREG/4, the operation is refused in the same way as in R1. A product exactly equal to NUM_VREG/4 is accepted.
- R3: The read for element i, field f uses address base + (i × fieldcount + f) × bytes, and rd_req_size carries the width code. While rd_req_ready is low, a pending request keeps its valid and its address.
- R4: Field f of element i is written to register dst_base + f × group_mul (modulo NUM_VREG), with wr_elem = i. The write data is the response reduced to the element width and zero-extended to 64 bits.
- R5: Reads are issued in ascending field order within an element and in ascending element order. No new request is issued before the previous response has been written.
- R6: Elements 0 up to (but not including) min(vl_req, vl_max, MAX_VL) are visited. A limit of 0 gives done with no reads.
- R7: An element whose bit in elem_mask (bit i for element i, 1 = active) is 0 gets no read and no write.
- R8: A zero field is written, and the next cycle then brings done with truncated=1 and vl_out = its element index. No further reads follow.
- R9: done is high for exactly one cycle. After a normal end, truncated=0 and vl_out equals vl_req as captured at start.
- R10: While busy, start is ignored. Input changes after the start cycle do not affect the running operation.
- R11: After reset busy, done, rd_req_valid and wr_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| ew_sel | input | 3 | Element width code |
| nf_sel | input | 3 | Field count minus one |
| group_mul | input | 4 | Register group multiplier (integer) |
| base_addr | input | ADDR_W | Address of element 0, field 0 |
| dst_base | input | REG_W | First destination register |
| vl_req | input | LEN_W | Requested vector length |
| vl_max | input | LEN_W | Maximum vector length |
| elem_mask | input | MAX_VL | Per-element enable |
| busy | output | 1 | Operation in progress |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory accepts request |
| rd_req_addr | output | ADDR_W | Read byte address |
| rd_req_size | output | 2 | Read size, log2 of bytes |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 64 | Read data |
| wr_en | output | 1 | Register write strobe |
| wr_reg | output | REG_W | Destination register number |
| wr_elem | output | LEN_W | Element position within the group |
| wr_data | output | 64 | Zero-extended element value |
| done | output | 1 | One-cycle completion pulse |
| truncated | output | 1 | Length was cut by a zero field |
| illegal | output | 1 | Configuration was refused |
| vl_out | output | LEN_W | Resulting vector length |

## Verification
The bench uses the defaults NUM_VREG=32, MAX_VL=16 and ADDR_W=32. A group limit of 8 lets both the accepted boundary (8 fields × 1) and a refused product (5 × 2) be reached. A mask capacity of 16 lets a requested length of 20 show the clamp. All four widths are exercised with response words that carry non-zero upper bits, so the width reduction and the zero test on the reduced value are both visible. This includes a word that is zero only in its low 16 bits. Back-pressure on the request channel and a second start in mid-run cover the handshake hold and the configuration capture.

// File: rtl/seg_vload_pkg.sv
package seg_vload_pkg;
    localparam int DATA_W = 64;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_ISSUE,
        S_WAIT,
        S_FIN
    } seq_st_e;
endpackage

// File: rtl/seg_vload_cfgchk.sv
module seg_vload_cfgchk #(
    parameter int NUM_VREG = 32
) (
    input  logic [2:0] ew_sel,
    input  logic [2:0] nf_sel,
    input  logic [3:0] group_mul,
    output logic [3:0] nf_cnt,
    output logic       legal
);
    localparam int GROUP_LIM = NUM_VREG / 4;

    logic [7:0] span;

    always_comb begin
        nf_cnt = {1'b0, nf_sel} + 4'd1;
        span   = 8'(nf_cnt) * 8'(group_mul);
        legal  = (ew_sel < 3'd4) && (int'(span) <= GROUP_LIM);
    end
endmodule

// File: rtl/seg_vload_agen.sv
module seg_vload_agen #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 5,
    parameter int REG_W  = 5
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  elem,
    input  logic [2:0]        field,
    input  logic [3:0]        nf_cnt,
    input  logic [1:0]        ew,
    input  logic [REG_W-1:0]  rd,
    input  logic [3:0]        gmul,
    output logic [ADDR_W-1:0] addr,
    output logic [REG_W-1:0]  dst
);
    localparam int IDX_W = LEN_W + 4;

    logic [IDX_W-1:0] slot;
    logic [6:0]       fofs;

    always_comb begin
        slot = IDX_W'(elem) * IDX_W'(nf_cnt) + IDX_W'(field);
        addr = base + (ADDR_W'(slot) << ew);
        fofs = 7'(field) * 7'(gmul);
        dst  = rd + REG_W'(fofs);
    end
endmodule

// File: rtl/seg_vload_zext.sv
module seg_vload_zext
    import seg_vload_pkg::*;
(
    input  logic [DATA_W-1:0] raw,
    input  logic [1:0]        ew,
    output logic [DATA_W-1:0] val,
    output logic              is_zero
);
    always_comb begin
        case (ew)
            2'd0:    val = {{(DATA_W-8){1'b0}},  raw[7:0]};
            2'd1:    val = {{(DATA_W-16){1'b0}}, raw[15:0]};
            2'd2:    val = {{(DATA_W-32){1'b0}}, raw[31:0]};
            default: val = raw;
        endcase
        is_zero = (val == '0);
    end
endmodule

// File: rtl/seg_vload_seq.sv
module seg_vload_seq
    import seg_vload_pkg::*;
#(
    parameter int  NUM_VREG = 32,
    parameter int  MAX_VL   = 16,
    parameter int  ADDR_W   = 32,
    localparam int REG_W    = $clog2(NUM_VREG),
    localparam int LEN_W    = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        ew_sel,
    input  logic [2:0]        nf_sel,
    input  logic [3:0]        group_mul,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [REG_W-1:0]  dst_base,
    input  logic [LEN_W-1:0]  vl_req,
    input  logic [LEN_W-1:0]  vl_max,
    input  logic [MAX_VL-1:0] elem_mask,
    output logic              busy,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic [1:0]        rd_req_size,
    input  logic              rd_rsp_valid,
    input  logic [DATA_W-1:0] rd_rsp_data,
    output logic              wr_en,
    output logic [REG_W-1:0]  wr_reg,
    output logic [LEN_W-1:0]  wr_elem,
    output logic [DATA_W-1:0] wr_data,
    output logic              done,
    output logic              truncated,
    output logic              illegal,
    output logic [LEN_W-1:0]  vl_out
);
    typedef struct packed {
        seq_st_e           st;
        logic [LEN_W-1:0]  elem;
        logic [2:0]        field;
        logic [LEN_W-1:0]  lim;
        logic [LEN_W-1:0]  vl_res;
        logic              trunc;
        logic              bad;
        logic [1:0]        ew;
        logic [3:0]        nf;
        logic [3:0]        gmul;
        logic [REG_W-1:0]  rd;
        logic [ADDR_W-1:0] base;
        logic [MAX_VL-1:0] mask;
    } seq_t;

    seq_t q, d;

    logic [3:0]        nf_in;
    logic              cfg_ok;
    logic [ADDR_W-1:0] cur_addr;
    logic [REG_W-1:0]  cur_dst;
    logic [DATA_W-1:0] rsp_val;
    logic              rsp_zero;
    logic [MAX_VL-1:0] mask_sh;
    logic [LEN_W-1:0]  lim_in;

    seg_vload_cfgchk #(.NUM_VREG(NUM_VREG)) u_cfg (
        .ew_sel    (ew_sel),
        .nf_sel    (nf_sel),
        .group_mul (group_mul),
        .nf_cnt    (nf_in),
        .legal     (cfg_ok)
    );

    seg_vload_agen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .REG_W(REG_W)) u_agen (
        .base   (q.base),
        .elem   (q.elem),
        .field  (q.field),
        .nf_cnt (q.nf),
        .ew     (q.ew),
        .rd     (q.rd),
        .gmul   (q.gmul),
        .addr   (cur_addr),
        .dst    (cur_dst)
    );

    seg_vload_zext u_zext (
        .raw     (rd_rsp_data),
        .ew      (q.ew),
        .val     (rsp_val),
        .is_zero (rsp_zero)
    );

    always_comb begin
        d       = q;
        mask_sh = q.mask >> q.elem;
        lim_in  = (vl_req < vl_max) ? vl_req : vl_max;
        if (lim_in > LEN_W'(MAX_VL)) begin
            lim_in = LEN_W'(MAX_VL);
        end

        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.elem   = '0;
                    d.field  = '0;
                    d.lim    = lim_in;
                    d.vl_res = vl_req;
                    d.trunc  = 1'b0;
                    d.bad    = !cfg_ok;
                    d.ew     = ew_sel[1:0];
                    d.nf     = nf_in;
                    d.gmul   = group_mul;
                    d.rd     = dst_base;
                    d.base   = base_addr;
                    d.mask   = elem_mask;
                    d.st     = cfg_ok ? S_SCAN : S_FIN;
                end
            end
            S_SCAN: begin
                if (q.elem >= q.lim) begin
                    d.st = S_FIN;
                end else if (!mask_sh[0]) begin
                    d.elem = q.elem + 1'b1;
                end else begin
                    d.st = S_ISSUE;
                end
            end
            S_ISSUE: begin
                if (rd_req_ready) begin
                    d.st = S_WAIT;
                end
            end
            S_WAIT: begin
                if (rd_rsp_valid) begin
                    if (rsp_zero) begin
                        d.trunc  = 1'b1;
                        d.vl_res = q.elem;
                        d.st     = S_FIN;
                    end else if ({1'b0, q.field} == q.nf - 4'd1) begin
                        d.field = '0;
                        d.elem  = q.elem + 1'b1;
                        d.st    = S_SCAN;
                    end else begin
                        d.field = q.field + 1'b1;
                        d.st    = S_ISSUE;
                    end
                end
            end
            S_FIN: begin
                d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        busy         = (q.st != S_IDLE);
        rd_req_valid = (q.st == S_ISSUE);
        rd_req_addr  = cur_addr;
        rd_req_size  = q.ew;
        wr_en        = (q.st == S_WAIT) && rd_rsp_valid;
        wr_reg       = cur_dst;
        wr_elem      = q.elem;
        wr_data      = rsp_val;
        done         = (q.st == S_FIN);
        truncated    = q.trunc;
        illegal      = q.bad;
        vl_out       = q.vl_res;
    end
endmodule

// File: rtl/seg_vload_chk.sv
module seg_vload_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_req_addr,
    input logic              wr_en,
    input logic [63:0]       wr_data,
    input logic              done,
    input logic              truncated,
    input logic              illegal
);
    // R5
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_valid && wr_en));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_data == 64'd0) |=> done && truncated);

    // R1
    refused_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && illegal |-> !truncated);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req_valid && !wr_en);
endmodule

bind seg_vload_seq seg_vload_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .done         (done),
    .truncated    (truncated),
    .illegal      (illegal)
);

// File: tb/sim_seg_vload_seq.sv
`timescale 1ns/1ps
module sim_seg_vload_seq;
    localparam int NV = 32;
    localparam int MV = 16;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] ew_sel = '0;
    logic [2:0] nf_sel = '0;
    logic [3:0] group_mul = 4'd1;
    logic [AW-1:0] base_addr = '0;
    logic [4:0] dst_base = '0;
    logic [4:0] vl_req = '0;
    logic [4:0] vl_max = '0;
    logic [MV-1:0] elem_mask = '0;
    logic busy, rd_req_valid, wr_en, done, truncated, illegal;
    logic rd_req_ready = 1'b1;
    logic [AW-1:0] rd_req_addr;
    logic [1:0] rd_req_size;
    logic rd_rsp_valid = 1'b0;
    logic [63:0] rd_rsp_data = '0;
    logic [4:0] wr_reg, wr_elem, vl_out;
    logic [63:0] wr_data;

    always #5 clk = ~clk;

    seg_vload_seq #(.NUM_VREG(NV), .MAX_VL(MV), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ew_sel(ew_sel), .nf_sel(nf_sel),
        .group_mul(group_mul), .base_addr(base_addr), .dst_base(dst_base),
        .vl_req(vl_req), .vl_max(vl_max), .elem_mask(elem_mask), .busy(busy),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_req_size(rd_req_size),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .wr_en(wr_en),
        .wr_reg(wr_reg), .wr_elem(wr_elem), .wr_data(wr_data), .done(done),
        .truncated(truncated), .illegal(illegal), .vl_out(vl_out)
    );

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    logic [AW-1:0] zaddr = '1;
    logic [63:0]   zval = '0;
    logic          stall = 1'b0;

    logic [AW-1:0] rd_log [1024];
    logic [1:0]    sz_log [1024];
    logic [4:0]    wreg_log [1024];
    logic [4:0]    welem_log [1024];
    logic [63:0]   wdat_log [1024];
    int n_rd = 0;
    int n_wr = 0;
    int rsp_sent = 0;

    logic [AW-1:0] e_addr [256];
    logic [4:0]    e_reg [256];
    logic [4:0]    e_elem [256];
    logic [63:0]   e_data [256];
    int n_exp;
    bit e_trunc;
    bit e_bad;
    int e_vl;

    function automatic logic [63:0] memval(logic [AW-1:0] a);
        if (a == zaddr) return zval;
        return 64'hF1E2_D3C4_B5A6_9700 | 64'(a[7:0] | 8'h01);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rd_req_valid && rd_req_ready && n_rd < 1024) begin
            rd_log[n_rd] = rd_req_addr;
            sz_log[n_rd] = rd_req_size;
            n_rd = n_rd + 1;
        end
        if (wr_en && n_wr < 1024) begin
            wreg_log[n_wr]  = wr_reg;
            welem_log[n_wr] = wr_elem;
            wdat_log[n_wr]  = wr_data;
            n_wr = n_wr + 1;
        end
    end

    always @(negedge clk) begin
        rd_req_ready <= stall ? ~rd_req_ready : 1'b1;
        if (n_rd > rsp_sent) begin
            rd_rsp_valid <= 1'b1;
            rd_rsp_data  <= memval(rd_log[rsp_sent]);
            rsp_sent = rsp_sent + 1;
        end else begin
            rd_rsp_valid <= 1'b0;
            rd_rsp_data  <= 64'hDEAD_0000_0000_BEEF;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks + 1, n_err + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model(input int ew, input int nfs, input int gm, input logic [AW-1:0] base,
                         input int rd, input int vl, input int vm, input logic [MV-1:0] msk);
        int nf = nfs + 1;
        int lim = (vl < vm) ? vl : vm;
        bit stop = 0;
        logic [63:0] wm;
        if (lim > MV) lim = MV;
        n_exp = 0;
        e_trunc = 0;
        e_vl = vl;
        e_bad = (ew > 3) || (nf * gm > NV / 4);
        if (e_bad) return;
        wm = (ew == 3) ? '1 : ((64'd1 << (8 << ew)) - 1);
        for (int i = 0; i < lim && !stop; i++) begin
            if (msk[i]) begin
                for (int f = 0; f < nf && !stop; f++) begin
                    e_addr[n_exp] = base + AW'((i * nf + f) << ew);
                    e_reg[n_exp]  = 5'((rd + f * gm) % NV);
                    e_elem[n_exp] = 5'(i);
                    e_data[n_exp] = memval(e_addr[n_exp]) & wm;
                    if (e_data[n_exp] == 0) begin
                        stop = 1;
                        e_trunc = 1;
                        e_vl = i;
                    end
                    n_exp++;
                end
            end
        end
    endtask

    task automatic run_case(input string nm, input int ew, input int nfs, input int gm,
                            input logic [AW-1:0] base, input int rd, input int vl, input int vm,
                            input logic [MV-1:0] msk, input bit restart);
        int r0 = n_rd;
        int w0 = n_wr;
        int t = 0;
        bit seen = 0;
        model(ew, nfs, gm, base, rd, vl, vm, msk);
        @(negedge clk);
        ew_sel = 3'(ew); nf_sel = 3'(nfs); group_mul = 4'(gm); base_addr = base;
        dst_base = 5'(rd); vl_req = 5'(vl); vl_max = 5'(vm); elem_mask = msk;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R10: change inputs and restart while busy
        if (restart) begin
            @(negedge clk);
            @(negedge clk);
            base_addr = 32'h0000_9000; dst_base = 5'd1; vl_req = 5'd2; elem_mask = '0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!seen && t < 3000) begin
            if (done) seen = 1;
            else begin
                @(negedge clk);
                t++;
            end
        end
        chk(seen, {nm, " R9 done seen"}, seen, 1);
        if (!seen) return;
        chk(illegal == e_bad, {nm, " R1 R2 illegal flag"}, illegal, e_bad);
        chk(truncated == e_trunc, {nm, " R8 truncated flag"}, truncated, e_trunc);
        chk(vl_out == 5'(e_vl), {nm, " R8 R9 vl_out"}, vl_out, e_vl);
        chk(n_rd - r0 == n_exp, {nm, " R5 R6 R7 read count"}, n_rd - r0, n_exp);
        chk(n_wr - w0 == n_exp, {nm, " R4 R7 write count"}, n_wr - w0, n_exp);
        for (int k = 0; k < n_exp && k < n_rd - r0; k++) begin
            chk(rd_log[r0+k] == e_addr[k], {nm, " R3 R5 read address"}, rd_log[r0+k], e_addr[k]);
            chk(sz_log[r0+k] == 2'(ew), {nm, " R3 read size"}, sz_log[r0+k], ew);
        end
        for (int k = 0; k < n_exp && k < n_wr - w0; k++) begin
            chk(wreg_log[w0+k] == e_reg[k], {nm, " R4 write register"}, wreg_log[w0+k], e_reg[k]);
            chk(welem_log[w0+k] == e_elem[k], {nm, " R4 write element"}, welem_log[w0+k], e_elem[k]);
            chk(wdat_log[w0+k] == e_data[k], {nm, " R4 write data"}, wdat_log[w0+k], e_data[k]);
        end
        @(negedge clk);
        chk(!done, {nm, " R9 done one cycle"}, done, 0);
        chk(!busy, {nm, " R9 idle after done"}, busy, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        // R11
        chk(!busy && !done, "R11 busy/done at reset", {busy, done}, 0);
        chk(!rd_req_valid && !wr_en, "R11 req/wr at reset", {rd_req_valid, wr_en}, 0);
    endtask

    task automatic t_basic();
        zaddr = '1;
        run_case("basic32", 2, 1, 2, 32'h1000, 4, 5, 8, 16'hFFFF, 0);
    endtask

    task automatic t_mask8();
        // R7 R6: mask gaps, limit from vl_max
        run_case("mask8", 0, 2, 1, 32'h40, 8, 8, 6, 16'h00A6, 0);
    endtask

    task automatic t_clamp64();
        // R6 clamp to MAX_VL, R3 back-pressure
        stall = 1'b1;
        run_case("clamp64", 3, 0, 8, 32'h2000, 0, 20, 20, 16'hFFFF, 0);
        stall = 1'b0;
    endtask

    task automatic t_trunc16();
        // R8 zero only in low 16 bits, R10 restart ignored
        zaddr = 32'h214; zval = 64'hFFFF_0000_0000_0000;
        run_case("trunc16", 1, 2, 2, 32'h200, 2, 6, 8, 16'hFFFF, 1);
        zaddr = '1;
    endtask

    task automatic t_trunc_first();
        // R8 first field of first element zero
        zaddr = 32'h300; zval = 64'd0;
        run_case("trunc0", 2, 3, 1, 32'h300, 0, 4, 4, 16'hFFFF, 0);
        zaddr = '1;
    endtask

    task automatic t_masked_zero();
        // R7 zero in a masked element is never read
        zaddr = 32'h508; zval = 64'd0;
        run_case("maskzero", 3, 0, 1, 32'h500, 3, 4, 4, 16'hFFFD, 0);
        zaddr = '1;
    endtask

    task automatic t_illegal();
        // R1 width code 5, R2 product 10 > 8, R2 boundary 8 accepted
        run_case("badwidth", 5, 0, 1, 32'h0, 0, 3, 3, 16'hFFFF, 0);
        run_case("badgroup", 0, 4, 2, 32'h0, 0, 3, 3, 16'hFFFF, 0);
        run_case("edgegroup", 0, 7, 1, 32'h700, 16, 2, 2, 16'hFFFF, 0);
    endtask

    task automatic t_zero_len();
        // R6 vl of zero
        run_case("vlzero", 2, 0, 1, 32'h800, 0, 0, 8, 16'hFFFF, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_mask8();
        t_clamp64();
        t_trunc16();
        t_trunc_first();
        t_masked_zero();
        t_illegal();
        t_zero_len();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule